// File: doc/BRIEF.md
# Transmit DMA Run-State Controller

This block is the control state machine of a descriptor-driven transmit DMA. Its inputs are a level run command, the base address of a descriptor ring, the answer of a descriptor fetch port (handshake, ownership bit, end-of-ring bit) and a frame-complete pulse from the data path. From these it decides whether the engine is Stopped, Running or Suspended. It also keeps the pointer to the current descriptor and raises a sticky flag when it finds a descriptor that software has not handed over.

Starting the engine fetches the descriptor at the current pointer. The first start after reset takes the pointer from the base address. Later starts resume from the position saved when the engine last stopped. A descriptor owned by the DMA begins a frame, and when that frame completes the pointer moves to the next ring entry. A descriptor not owned by the DMA parks the engine in Suspended until software asks for a new fetch or stops the engine. Dropping the run command never cuts a frame short.

Top module: `tx_dma_run_ctl`

## Requirements
- R1: After reset, run_state is 2'b00 (Stopped), fetch_req and xmit_busy are 0, unavail is 0 and cur_ptr is 0.
- R2: run_state encodes 2'b00 Stopped, 2'b01 Running (fetching or sending) and 2'b10 Suspended. If run_cmd is 1 while Stopped, the next cycle shows Running with fetch_req high.
- R3: The first start after reset loads cur_ptr from list_base. Whenever fetch_req is high, fetch_addr equals cur_ptr.
- R4: fetch_req stays high, with a stable address, until a cycle with fetch_ack high. An ack with fetch_owned=1 sets xmit_busy in the next cycle.
- R5: An ack with fetch_owned=0 moves the block to Suspended and sets unavail in the next cycle. unavail stays 1 until a cycle with unavail_clr high. A new set wins over a clear in the same cycle.
- R6: While Suspended with run_cmd high, a poll_demand pulse starts a new fetch of the same cur_ptr. Without poll_demand the block stays Suspended.
- R7: frame_done while xmit_busy advances cur_ptr by DESC_BYTES modulo 2^AW. If the end-of-ring bit was 1 when that descriptor was accepted, cur_ptr returns to list_base instead. If run_cmd is still high, the next fetch follows at once.
- R8: If run_cmd is 0 during a frame, the block stays Running with xmit_busy high until frame_done. After that it is Stopped, and cur_ptr holds the next position.
- R9: If run_cmd is 0 while Suspended, the block is Stopped in the next cycle and cur_ptr is unchanged.
- R10: A start after a stop resumes at the saved cur_ptr, even when list_base has changed since.
- R11: Inputs that are not expected in the current state have no effect on any output. This covers fetch_ack outside a fetch, frame_done outside a frame, and poll_demand outside Suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_cmd | input | 1 | Run (1) or stop (0) command level |
| list_base | input | AW | Descriptor ring base address |
| poll_demand | input | 1 | Pulse: retry the fetch while Suspended |
| unavail_clr | input | 1 | Pulse: clear the unavailable flag |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | AW | Address of the descriptor to fetch |
| fetch_ack | input | 1 | Fetch response valid |
| fetch_owned | input | 1 | Fetched descriptor belongs to the DMA |
| fetch_eor | input | 1 | Fetched descriptor is the last in the ring |
| frame_done | input | 1 | Pulse: the data path finished the frame |
| xmit_busy | output | 1 | A frame is in progress |
| run_state | output | 2 | 00 Stopped, 01 Running, 10 Suspended |
| cur_ptr | output | AW | Current descriptor position |
| unavail | output | 1 | Sticky buffer-unavailable flag |

## Verification
The bench builds the block with AW=8 and DESC_BYTES=32, so the ring has eight slots. Plain increments therefore reach the 2^AW wrap within a few frames, apart from the end-of-ring return to the base. Long random runs cover both pointer wrap paths, and they also reach stops and restarts at positions other than the base.

// File: rtl/tx_dma_run_ctl.sv
module tx_dma_run_ctl #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_cmd,
  input  logic [AW-1:0] list_base,
  input  logic          poll_demand,
  input  logic          unavail_clr,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic          fetch_owned,
  input  logic          fetch_eor,
  input  logic          frame_done,
  output logic          xmit_busy,
  output logic [1:0]    run_state,
  output logic [AW-1:0] cur_ptr,
  output logic          unavail
);

  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XMIT, S_SUSP} st_t;

  st_t           st, st_nx;
  logic          have_pos;
  logic          eor_q;
  logic [AW-1:0] ptr_nx;

  wire ack_ok  = (st == S_FETCH) && fetch_ack && fetch_owned;
  wire ack_bad = (st == S_FETCH) && fetch_ack && !fetch_owned;
  wire done_ok = (st == S_XMIT) && frame_done;

  assign fetch_req  = (st == S_FETCH);
  assign xmit_busy  = (st == S_XMIT);
  assign fetch_addr = cur_ptr;
  assign run_state  = (st == S_IDLE) ? 2'b00 : (st == S_SUSP) ? 2'b10 : 2'b01;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (run_cmd) st_nx = S_FETCH;
      S_FETCH: if (ack_ok) st_nx = S_XMIT;
               else if (ack_bad) st_nx = S_SUSP;
      S_XMIT:  if (frame_done) st_nx = run_cmd ? S_FETCH : S_IDLE;
      S_SUSP:  if (!run_cmd) st_nx = S_IDLE;
               else if (poll_demand) st_nx = S_FETCH;
    endcase
  end

  always_comb begin
    ptr_nx = cur_ptr;
    if (st == S_IDLE && run_cmd && !have_pos) ptr_nx = list_base;
    else if (done_ok) ptr_nx = eor_q ? list_base : cur_ptr + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_ptr  <= '0;
      have_pos <= 1'b0;
      eor_q    <= 1'b0;
      unavail  <= 1'b0;
    end else begin
      st      <= st_nx;
      cur_ptr <= ptr_nx;
      if (st == S_IDLE && run_cmd) have_pos <= 1'b1;
      if (ack_ok) eor_q <= fetch_eor;
      if (ack_bad) unavail <= 1'b1;
      else if (unavail_clr) unavail <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_dma_run_ctl_chk.sv
module tx_dma_run_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_cmd,
  input logic          unavail_clr,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_ack,
  input logic          fetch_owned,
  input logic          frame_done,
  input logic          xmit_busy,
  input logic [1:0]    run_state,
  input logic [AW-1:0] cur_ptr,
  input logic          unavail
);

  always_comb begin
    if (rst_n) p_state_legal_r2: assert (run_state != 2'b11);
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'b00 && run_cmd) |=> (run_state == 2'b01 && fetch_req));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

  p_owned_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && fetch_owned) |=> xmit_busy);

  p_unavail_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !fetch_owned) |=> (unavail && run_state == 2'b10));

  p_unavail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unavail && !unavail_clr) |=> unavail);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_busy && !frame_done) |=> (xmit_busy && run_state == 2'b01));

  p_susp_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'b10 && !run_cmd) |=> (run_state == 2'b00 && $stable(cur_ptr)));

  p_ptr_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state != 2'b00 && !(xmit_busy && frame_done)) |=> $stable(cur_ptr));

endmodule

bind tx_dma_run_ctl tx_dma_run_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .unavail_clr(unavail_clr),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
  .fetch_owned(fetch_owned), .frame_done(frame_done), .xmit_busy(xmit_busy),
  .run_state(run_state), .cur_ptr(cur_ptr), .unavail(unavail)
);

// File: tb/tb_tx_dma_run_ctl.sv
`timescale 1ns/1ps
module tb_tx_dma_run_ctl;
  localparam int AW = 8;
  localparam int DB = 32;

  logic clk = 0, rst_n = 0;
  logic run_cmd = 0, poll_demand = 0, unavail_clr = 0;
  logic fetch_ack = 0, fetch_owned = 0, fetch_eor = 0, frame_done = 0;
  logic [AW-1:0] list_base = '0;
  logic fetch_req, xmit_busy, unavail;
  logic [AW-1:0] fetch_addr, cur_ptr;
  logic [1:0] run_state;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_st = 0;
  logic [AW-1:0] m_ptr = '0;
  bit m_have = 0, m_eor = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  tx_dma_run_ctl #(.AW(AW), .DESC_BYTES(DB)) dut (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .list_base(list_base),
    .poll_demand(poll_demand), .unavail_clr(unavail_clr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_owned(fetch_owned), .fetch_eor(fetch_eor), .frame_done(frame_done),
    .xmit_busy(xmit_busy), .run_state(run_state), .cur_ptr(cur_ptr),
    .unavail(unavail));

  function automatic logic [1:0] enc(int s);
    return (s == 0) ? 2'b00 : (s == 3) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p, bit wrap, logic [AW-1:0] b);
    return wrap ? b : AW'(p + DB);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 run_state", 32'(run_state), 32'(enc(m_st)));
    chk("R4 fetch_req", 32'(fetch_req), 32'(m_st == 1));
    chk("R8 xmit_busy", 32'(xmit_busy), 32'(m_st == 2));
    chk("R7 cur_ptr", 32'(cur_ptr), 32'(m_ptr));
    chk("R3 fetch_addr", 32'(fetch_addr), 32'(m_ptr));
    chk("R5 unavail", 32'(unavail), 32'(m_flag));
  endtask

  task automatic step(bit rc, bit ack, bit own, bit eor, bit fd, bit poll, bit clr);
    bit setf = 0;
    run_cmd = rc; fetch_ack = ack; fetch_owned = own; fetch_eor = eor;
    frame_done = fd; poll_demand = poll; unavail_clr = clr;
    case (m_st)
      0: if (rc) begin
           if (!m_have) begin m_ptr = list_base; m_have = 1; end
           m_st = 1;
         end
      1: if (ack) begin
           if (own) begin m_st = 2; m_eor = eor; end
           else begin m_st = 3; setf = 1; end
         end
      2: if (fd) begin m_ptr = adv(m_ptr, m_eor, list_base); m_st = rc ? 1 : 0; end
      default: if (!rc) m_st = 0; else if (poll) m_st = 1;
    endcase
    if (setf) m_flag = 1; else if (clr) m_flag = 0;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 state", 32'(run_state), 0);
    chk("R1 req", 32'(fetch_req), 0);
    chk("R1 busy", 32'(xmit_busy), 0);
    chk("R1 flag", 32'(unavail), 0);
    chk("R1 ptr", 32'(cur_ptr), 0);

    list_base = 8'h40;
    step(1,0,0,0,0,0,0);
    chk("R3 first start base", 32'(cur_ptr), 32'h40);
    step(1,0,0,0,0,0,0);                       // R4 hold without ack
    step(1,1,1,0,0,0,0);                       // owned -> frame
    step(1,1,0,0,0,0,0);                       // R11 ack during frame ignored
    chk("R11 stray ack", 32'(xmit_busy), 1);
    step(1,0,0,0,1,0,0);
    chk("R7 advance", 32'(cur_ptr), 32'h60);
    step(1,1,1,1,0,0,0);
    step(1,0,0,0,1,0,0);
    chk("R7 ring return", 32'(cur_ptr), 32'h40);
    step(1,1,0,0,0,0,0);
    chk("R5 suspend", 32'(run_state), 32'h2);
    chk("R5 flag set", 32'(unavail), 1);
    step(1,0,0,0,0,0,0);
    chk("R6 stays suspended", 32'(run_state), 32'h2);
    chk("R5 sticky", 32'(unavail), 1);
    step(1,0,0,0,0,0,1);
    chk("R5 cleared", 32'(unavail), 0);
    step(1,0,0,0,0,1,0);
    chk("R6 refetch", 32'(fetch_req), 1);
    chk("R6 same ptr", 32'(fetch_addr), 32'h40);
    step(1,1,1,0,0,0,0);
    step(0,0,0,0,0,0,0);
    chk("R8 waits frame", 32'(run_state), 32'h1);
    step(0,0,0,0,1,0,0);
    chk("R8 stopped", 32'(run_state), 0);
    chk("R8 saved ptr", 32'(cur_ptr), 32'h60);
    step(0,0,0,0,1,1,0);
    chk("R11 stray done", 32'(cur_ptr), 32'h60);
    list_base = 8'h80;
    step(1,0,0,0,0,0,0);
    chk("R10 resume", 32'(fetch_addr), 32'h60);
    step(1,1,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    chk("R9 stop from suspend", 32'(run_state), 0);
    chk("R9 ptr kept", 32'(cur_ptr), 32'h60);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 3) list_base = AW'($urandom);
      step($urandom_range(99) < 85, $urandom_range(1), $urandom_range(99) < 75,
           $urandom_range(99) < 15, $urandom_range(99) < 35,
           $urandom_range(99) < 30, $urandom_range(99) < 10);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule